// File: doc/BRIEF.md
# Interleaved Serial Slot Framer

This block is the serial front end of a multichannel voice transcoder. A single input line carries 8-bit words, most significant bit first, and each bit is held for two system clocks, so one word fills 16 clocks. Slots alternate between a PCM word, which feeds an encoder, and an ADPCM word, which feeds a decoder. Each PCM/ADPCM pair belongs to one channel, so one channel takes 32 clocks. The block recovers each word and tags it with its channel number and its direction. It hands the word to the processing stage and takes back the processed word. It then drives the result onto a parallel bus with a per-direction strobe, and shifts it out on a single serial output line in the same interleaved order.

Framing is tied to a sync input. In the normal mode its falling edge restarts the word and channel counters. A mode input makes the rising edge the active one instead. A clock-enable input lets the system gap the clock; cycles with the enable low do not advance anything. A per-channel transparency mask makes a channel bypass processing, so its received word goes out unchanged.

Top module: `slot_serial_framer`

## Requirements
- R1: While reset is asserted, ser_o is 0, both strobes are high, rx_valid_o is 0 and par_o is 0.
- R2: The input bit for word position b (b = 7 is sent first) is the value on ser_i during the second of its two clocks. After the 16th clock of a slot, rx_valid_o is high for exactly one enabled cycle, and rx_word_o then holds the assembled word.
- R3: Slots are counted from 0 after the active sync edge. Slot s has rx_dec_o = s mod 2 (0 for PCM/encoder, 1 for ADPCM/decoder) and rx_chan_o = s/2. After slot 2*NCH-1 the count wraps to slot 0 without needing another sync edge.
- R4: The output word for slot k is sent on ser_o during slot k+2, MSB first, and each bit is held for two clocks. During the first two slots after a restart, ser_o is 0.
- R5: If the channel's bit in xpar_i is 0, the output word is proc_word_i as sampled in the cycle where rx_valid_o is high. If the bit is 1, the output word is the received word unchanged. The same word goes to ser_o and to par_o.
- R6: For slot k, par_o is loaded during clock 0 of slot k+1. One strobe is then low during clocks 2 and 3 of slot k+1: pcm_stb_n_o if k is even, adpcm_stb_n_o if k is odd. The two strobes are never low together, and par_o does not change while a strobe is low or at its rising edge.
- R7: With rise_sync_i = 0, an enabled cycle in which sync_i falls makes the next cycle clock 0 of slot 0. A rising edge of sync_i has no effect.
- R8: With rise_sync_i = 1, only the rising edge of sync_i restarts the framing, in the same way as R7.
- R9: A restart discards any partly received word and any word waiting to be sent. None of these produces an rx_valid_o pulse or a strobe, and ser_o is 0 for the first 16 clocks after the restart.
- R10: In a cycle with clk_en low, no state changes, so every output holds its value into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock enable for gapped operation |
| sync_i | input | 1 | Frame sync; only its active edge matters |
| rise_sync_i | input | 1 | 1 makes the rising sync edge active, 0 the falling edge |
| ser_i | input | 1 | Interleaved serial input, two clocks per bit |
| xpar_i | input | NCH | Per-channel transparency mask |
| proc_word_i | input | 8 | Processed word returned by the processing stage |
| rx_word_o | output | 8 | Last received word |
| rx_valid_o | output | 1 | Received word is ready |
| rx_chan_o | output | $clog2(NCH) | Channel of the received word |
| rx_dec_o | output | 1 | 0 for a PCM (encoder) slot, 1 for an ADPCM (decoder) slot |
| ser_o | output | 1 | Interleaved serial output |
| par_o | output | 8 | Parallel output word |
| pcm_stb_n_o | output | 1 | Active-low strobe for PCM-slot words |
| adpcm_stb_n_o | output | 1 | Active-low strobe for ADPCM-slot words |

## Verification
If the bit phase is off by one, the word assembled in the first slot comes out shifted, and the strobes fall on the wrong clocks within the first 17 cycles. If the slot counter is wrong, rx_chan_o or rx_dec_o is wrong at the very next rx_valid_o pulse. A wrong wrap point shows only after 2*NCH slots, so the bench runs past a full frame without any sync edge. A restart that clears the wrong state shows within two slots: either a stale word appears on ser_o, or a strobe pulses for a word that was aborted.

// File: rtl/ssf_pkg.sv
package ssf_pkg;
    localparam int WORD_W = 8;
    localparam int CLK_PER_WORD = 2 * WORD_W;
    localparam int PH_W = $clog2(CLK_PER_WORD);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLK_PER_WORD - 1);
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/ssf_timebase.sv
module ssf_timebase
    import ssf_pkg::*;
#(
    parameter int NCH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sync_i,
    input  logic rise_sel_i,
    output logic restart_o,
    output logic [PH_W-1:0] ph_o,
    output logic [$clog2(2*NCH)-1:0] slot_o
);
    localparam int NSLOT = 2 * NCH;
    localparam int SW = $clog2(NSLOT);

    typedef struct packed {
        logic          sync;
        logic [PH_W-1:0] ph;
        logic [SW-1:0] slot;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic edge_seen;

    always_comb begin
        st_d = st_q;
        edge_seen = rise_sel_i ? (sync_i & ~st_q.sync) : (~sync_i & st_q.sync);
        restart_o = en & edge_seen;
        if (en) begin
            st_d.sync = sync_i;
            if (edge_seen) begin
                st_d.ph = '0;
                st_d.slot = '0;
            end else begin
                st_d.ph = st_q.ph + 1'b1;
                if (st_q.ph == PH_LAST) begin
                    st_d.slot = (st_q.slot == SW'(NSLOT - 1)) ? '0 : st_q.slot + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ph_o = st_q.ph;
    assign slot_o = st_q.slot;
endmodule

// File: rtl/ssf_rx.sv
module ssf_rx
    import ssf_pkg::*;
#(
    parameter int NCH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic restart_i,
    input  logic [PH_W-1:0] ph_i,
    input  logic [$clog2(2*NCH)-1:0] slot_i,
    input  logic ser_i,
    output word_t word_o,
    output logic valid_o,
    output logic [$clog2(NCH)-1:0] chan_o,
    output logic dec_o
);
    localparam int SW = $clog2(2 * NCH);
    localparam int CW = $clog2(NCH);

    typedef struct packed {
        word_t         sh;
        word_t         word;
        logic          valid;
        logic [CW-1:0] chan;
        logic          dec;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en) begin
            st_d.valid = 1'b0;
            if (restart_i) begin
                st_d.sh = '0;
            end else begin
                if (ph_i[0]) st_d.sh = {st_q.sh[WORD_W-2:0], ser_i};
                if (ph_i == PH_LAST) begin
                    st_d.word  = {st_q.sh[WORD_W-2:0], ser_i};
                    st_d.valid = 1'b1;
                    st_d.chan  = slot_i[SW-1:1];
                    st_d.dec   = slot_i[0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o = st_q.word;
    assign valid_o = st_q.valid;
    assign chan_o = st_q.chan;
    assign dec_o = st_q.dec;
endmodule

// File: rtl/ssf_tx.sv
module ssf_tx
    import ssf_pkg::*;
#(
    parameter int NCH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic restart_i,
    input  logic [PH_W-1:0] ph_i,
    input  word_t rx_word_i,
    input  logic rx_valid_i,
    input  logic [$clog2(NCH)-1:0] rx_chan_i,
    input  logic rx_dec_i,
    input  logic [NCH-1:0] xpar_i,
    input  word_t proc_word_i,
    output logic ser_o,
    output word_t par_o,
    output logic pcm_stb_n_o,
    output logic adpcm_stb_n_o
);
    typedef struct packed {
        word_t hold;
        logic  hdec;
        logic  hv;
        word_t sh;
        logic  pstb_n;
        logic  astb_n;
    } tx_state_t;

    tx_state_t st_d, st_q;
    logic win;

    always_comb begin
        st_d = st_q;
        win = st_q.hv && (ph_i == PH_W'(1) || ph_i == PH_W'(2));
        if (en) begin
            if (restart_i) begin
                st_d.hv = 1'b0;
                st_d.sh = '0;
                st_d.pstb_n = 1'b1;
                st_d.astb_n = 1'b1;
            end else begin
                if (rx_valid_i) begin
                    st_d.hold = xpar_i[rx_chan_i] ? rx_word_i : proc_word_i;
                    st_d.hdec = rx_dec_i;
                    st_d.hv = 1'b1;
                end
                if (ph_i == PH_LAST) begin
                    st_d.sh = st_q.hv ? st_q.hold : '0;
                    st_d.hv = 1'b0;
                end else if (ph_i[0]) begin
                    st_d.sh = {st_q.sh[WORD_W-2:0], 1'b0};
                end
                st_d.pstb_n = ~(win & ~st_q.hdec);
                st_d.astb_n = ~(win & st_q.hdec);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            st_q.pstb_n <= 1'b1;
            st_q.astb_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_o = st_q.sh[WORD_W-1];
    assign par_o = st_q.hold;
    assign pcm_stb_n_o = st_q.pstb_n;
    assign adpcm_stb_n_o = st_q.astb_n;
endmodule

// File: rtl/slot_serial_framer.sv
module slot_serial_framer
    import ssf_pkg::*;
#(
    parameter int NCH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    input  logic sync_i,
    input  logic rise_sync_i,
    input  logic ser_i,
    input  logic [NCH-1:0] xpar_i,
    input  logic [7:0] proc_word_i,
    output logic [7:0] rx_word_o,
    output logic rx_valid_o,
    output logic [$clog2(NCH)-1:0] rx_chan_o,
    output logic rx_dec_o,
    output logic ser_o,
    output logic [7:0] par_o,
    output logic pcm_stb_n_o,
    output logic adpcm_stb_n_o
);
    localparam int SW = $clog2(2 * NCH);

    logic restart_w;
    logic [PH_W-1:0] ph_w;
    logic [SW-1:0] slot_w;

    ssf_timebase #(.NCH(NCH)) u_tb (
        .clk(clk), .rst_n(rst_n), .en(clk_en),
        .sync_i(sync_i), .rise_sel_i(rise_sync_i),
        .restart_o(restart_w), .ph_o(ph_w), .slot_o(slot_w)
    );

    ssf_rx #(.NCH(NCH)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(clk_en),
        .restart_i(restart_w), .ph_i(ph_w), .slot_i(slot_w), .ser_i(ser_i),
        .word_o(rx_word_o), .valid_o(rx_valid_o),
        .chan_o(rx_chan_o), .dec_o(rx_dec_o)
    );

    ssf_tx #(.NCH(NCH)) u_tx (
        .clk(clk), .rst_n(rst_n), .en(clk_en),
        .restart_i(restart_w), .ph_i(ph_w),
        .rx_word_i(rx_word_o), .rx_valid_i(rx_valid_o),
        .rx_chan_i(rx_chan_o), .rx_dec_i(rx_dec_o),
        .xpar_i(xpar_i), .proc_word_i(proc_word_i),
        .ser_o(ser_o), .par_o(par_o),
        .pcm_stb_n_o(pcm_stb_n_o), .adpcm_stb_n_o(adpcm_stb_n_o)
    );
endmodule

// File: rtl/ssf_check.sv
module ssf_check
    import ssf_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic clk_en,
    input logic restart,
    input logic [PH_W-1:0] ph,
    input logic slot_home,
    input logic rx_valid,
    input logic ser,
    input logic [7:0] par,
    input logic pstb_n,
    input logic astb_n
);
    assert_stb_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!pstb_n && !astb_n));

    assert_stb_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !restart && !pstb_n && $past(pstb_n)) |=> !pstb_n);

    assert_par_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pstb_n || !astb_n) |=> $stable(par));

    assert_gap_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(ser) && $stable(par) && $stable(pstb_n)
                     && $stable(astb_n) && $stable(rx_valid)));

    assert_valid_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (ph == '0));

    assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && clk_en) |=> !rx_valid);

    assert_restart_home_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (ph == '0 && slot_home));
endmodule

bind slot_serial_framer ssf_check u_chk (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .restart(restart_w),
    .ph(ph_w), .slot_home(slot_w == '0), .rx_valid(rx_valid_o),
    .ser(ser_o), .par(par_o), .pstb_n(pcm_stb_n_o), .astb_n(adpcm_stb_n_o)
);

// File: tb/slot_serial_framer_test.sv
module slot_serial_framer_test;
    localparam int NCH = 32;

    logic clk = 0;
    logic rst_n = 0;
    logic clk_en = 1;
    logic sync_i = 1;
    logic rise_sync_i = 0;
    logic ser_i = 0;
    logic [NCH-1:0] xpar_i = '0;
    logic [7:0] proc_word;
    logic [7:0] rx_word_o;
    logic rx_valid_o;
    logic [$clog2(NCH)-1:0] rx_chan_o;
    logic rx_dec_o, ser_o, pcm_stb_n_o, adpcm_stb_n_o;
    logic [7:0] par_o;

    // processing stub: bitwise inversion
    assign proc_word = ~rx_word_o;

    slot_serial_framer #(.NCH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sync_i(sync_i),
        .rise_sync_i(rise_sync_i), .ser_i(ser_i), .xpar_i(xpar_i),
        .proc_word_i(proc_word), .rx_word_o(rx_word_o), .rx_valid_o(rx_valid_o),
        .rx_chan_o(rx_chan_o), .rx_dec_o(rx_dec_o), .ser_o(ser_o), .par_o(par_o),
        .pcm_stb_n_o(pcm_stb_n_o), .adpcm_stb_n_o(adpcm_stb_n_o)
    );

    always #10 clk = ~clk;

    int nchk = 0, nbad = 0, cyc = 0;
    bit done = 0;

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference: absolute time since restart and words per slot
    int t = 0;
    bit sp = 0;
    bit last_en = 1;
    int wrd[int];
    int outw[int];

    always @(posedge clk) begin
        if (!rst_n) begin
            t = 0; sp = 0; last_en = 1;
            wrd.delete(); outw.delete();
        end else begin
            last_en = clk_en;
            if (clk_en) begin
                bit ev;
                ev = rise_sync_i ? (sync_i && !sp) : (!sync_i && sp);
                sp = sync_i;
                if (ev) begin
                    t = 0; wrd.delete(); outw.delete();
                end else begin
                    int k, p, tmp, ch;
                    k = t / 16; p = t % 16;
                    if (p % 2 == 1) begin
                        tmp = wrd.exists(k) ? wrd[k] : 0;
                        tmp = tmp | (int'(ser_i) << (7 - p / 2));
                        wrd[k] = tmp;
                    end
                    if (p == 0 && k >= 1) begin
                        ch = ((k - 1) % (2 * NCH)) / 2;
                        outw[k - 1] = xpar_i[ch] ? wrd[k - 1] : ((~wrd[k - 1]) & 255);
                    end
                    t++;
                end
            end
        end
    end

    int pv_ser, pv_par, pv_ps, pv_as, pv_v;
    bit have_prev = 0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            int k, p, eser;
            bit ev, epl, eal;
            k = t / 16; p = t % 16;
            if (!last_en && have_prev) begin
                chk("R10 ser hold", ser_o, pv_ser);
                chk("R10 par hold", par_o, pv_par);
                chk("R10 stb hold", {pcm_stb_n_o, adpcm_stb_n_o}, {pv_ps[0], pv_as[0]});
                chk("R10 valid hold", rx_valid_o, pv_v);
            end
            ev = (p == 0 && k >= 1);
            chk("R2 rx_valid", rx_valid_o, ev);
            if (ev) begin
                chk("R2 rx_word", rx_word_o, wrd[k - 1]);
                chk("R3 channel", rx_chan_o, ((k - 1) % (2 * NCH)) / 2);
                chk("R3 direction", rx_dec_o, (k - 1) % 2);
            end
            epl = (k >= 1 && (p == 2 || p == 3) && (k - 1) % 2 == 0);
            eal = (k >= 1 && (p == 2 || p == 3) && (k - 1) % 2 == 1);
            chk("R6 pcm strobe", pcm_stb_n_o, !epl);
            chk("R6 adpcm strobe", adpcm_stb_n_o, !eal);
            if (epl || eal) chk("R5 par word", par_o, outw[k - 1]);
            eser = (k >= 2) ? ((outw[k - 2] >> (7 - p / 2)) & 1) : 0;
            chk("R4 ser bit", ser_o, eser);
            pv_ser = ser_o; pv_par = par_o; pv_ps = pcm_stb_n_o;
            pv_as = adpcm_stb_n_o; pv_v = rx_valid_o;
            have_prev = 1;
        end
    end

    initial forever @(negedge clk) ser_i = 1'($urandom_range(0, 1));

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            nbad++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    task automatic run(input int n, input bit gaps);
        repeat (n) @(negedge clk) clk_en = gaps ? ($urandom_range(0, 3) != 0) : 1'b1;
    endtask

    // restart via the active edge, then check the aborted state and the first new word
    task automatic do_sync(input bit rise);
        string tg;
        tg = rise ? "R8" : "R7";
        @(negedge clk); clk_en = 1; rise_sync_i = rise; sync_i = rise ? 1'b0 : 1'b1;
        @(negedge clk); sync_i = rise ? 1'b1 : 1'b0;
        @(negedge clk); sync_i = rise ? 1'b0 : 1'b1;
        for (int i = 0; i < 16; i++) begin
            chk("R9 no rx_valid after restart", rx_valid_o, 0);
            chk("R9 no strobe after restart", {pcm_stb_n_o, adpcm_stb_n_o}, 2'b11);
            chk("R9 ser quiet after restart", ser_o, 0);
            @(negedge clk);
        end
        chk({tg, " first word valid"}, rx_valid_o, 1);
        chk({tg, " slot 0 channel"}, rx_chan_o, 0);
        chk({tg, " slot 0 direction"}, rx_dec_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ser at reset", ser_o, 0);
        chk("R1 strobes at reset", {pcm_stb_n_o, adpcm_stb_n_o}, 2'b11);
        chk("R1 valid at reset", rx_valid_o, 0);
        chk("R1 par at reset", par_o, 0);
        rst_n = 1;
        run(300, 0);
        do_sync(0);
        run(1100, 0);               // beyond one full frame: R3 wrap
        xpar_i = 32'hA5A5_0F0F;     // R5 transparent channels
        run(600, 0);
        run(1500, 1);               // gapped clock: R10
        run(37, 0);
        do_sync(0);                 // mid-word restart: R9
        run(45, 1);
        xpar_i = 32'h0000_FFFF;
        do_sync(1);                 // rising-edge mode
        run(800, 1);
        run(100, 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule